// File: doc/BRIEF.md
# Chained Up/Down Binary Counter

This block is a synchronous binary counter built from two cascaded stages: a low stage that holds the bottom byte and a high stage that holds the top nibble, 12 bits in all with the default widths. The low stage raises a carry flag when its byte sits at its terminal value for the current direction. That flag gates the high stage, so the high stage moves only on the edge where the low byte wraps.

Four controls set what happens at each rising clock edge. An active-low clear acts at once, without waiting for the clock, and overrides everything else. A synchronous load copies a preset word into the counter. A count enable and a direction select pick increment, decrement or hold.

The block drives two terminal flags. Both are combinational decodes of the present count and direction, with no register stage. The low-byte flag ignores the count enable. The full-width flag marks the all-ones value when counting up and the all-zero value when counting down.

Top module: `chained_updown_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 at once, without waiting for a clock edge. It stays 0 across clock edges, even with `load` high.
- R2: With `rst_n` high and `load` high, a rising edge copies `preset` to `count`, whatever `cnt_en` and `dir_up` are.
- R3: With `rst_n` high, `load` low and `cnt_en` low, `count` keeps its value across a rising edge.
- R4: With `rst_n` high, `load` low, `cnt_en` high and `dir_up` high, a rising edge adds one to `count`, modulo 4096, so 4095 becomes 0.
- R5: With `rst_n` high, `load` low, `cnt_en` high and `dir_up` low, a rising edge subtracts one from `count`, modulo 4096, so 0 becomes 4095.
- R6: `tc_full` is 1 exactly when `dir_up` is 1 and `count` is 4095, or when `dir_up` is 0 and `count` is 0.
- R7: `tc_low` is 1 exactly when `dir_up` is 1 and `count[7:0]` is 255, or when `dir_up` is 0 and `count[7:0]` is 0. The value of `cnt_en` has no effect on it.
- R8: Apart from a load or a clear, `count[11:8]` changes only on an edge where `cnt_en` and `tc_low` are both 1. On such an edge it steps by one in the direction set by `dir_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, acts at once without the clock |
| load | input | 1 | Synchronous preset load, active high |
| preset | input | 12 | Value copied into the counter on a load |
| cnt_en | input | 1 | Count enable, active high |
| dir_up | input | 1 | Direction select: 1 counts up, 0 counts down |
| count | output | 12 | Present count, bit 11 is the MSB |
| tc_low | output | 1 | Low-byte terminal flag, gates the high stage |
| tc_full | output | 1 | Full-width terminal flag |

## Verification
The hardest situations to reach are the carry edge into the high nibble and the full-width terminal value. From reset, stepping there takes up to 4095 edges. The bench uses preset loads to place the counter one step below each byte and word boundary, and then steps across it in both directions. It also holds the enable low at those boundaries, to show that the low-byte flag stays up while the count stays still. One long up-count walk compares every edge against a model kept in the bench. That walk covers each carry into the high nibble and the final wrap to zero.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned LOW_W_DEF  = 8;
  localparam int unsigned HIGH_W_DEF = 4;

  // all-ones mask for a field of w bits (w below 32)
  function automatic logic [31:0] field_mask(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // next value of a w-bit field: one step up or down, wrapping
  function automatic logic [31:0] step_val(input logic [31:0] v, input logic up,
                                           input int unsigned w);
    logic [31:0] nv;
    nv = up ? v + 32'd1 : v - 32'd1;
    return nv & field_mask(w);
  endfunction

  // terminal decode: top value counting up, zero counting down
  function automatic logic is_term(input logic [31:0] v, input logic up,
                                   input int unsigned w);
    return up ? (v == field_mask(w)) : (v == 32'd0);
  endfunction
endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic         up,
  input  logic         tc_gate,
  output logic [W-1:0] q,
  output logic         tc
);
  logic [W-1:0] q_next;
  logic         at_term;

  assign q_next  = W'(step_val(32'(q), up, W));
  assign at_term = is_term(32'(q), up, W);
  assign tc      = tc_gate & at_term;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    q <= '0;
    else if (ld)   q <= ld_val;
    else if (step) q <= q_next;
  end

  // a stage that neither loads nor steps keeps its value (R3, R8)
  p_stage_hold_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (!ld && !step) |=> $stable(q));
endmodule

// File: rtl/chained_updown_counter.sv
module chained_updown_counter
  import cnt_pkg::*;
#(
  parameter int unsigned LOW_W  = LOW_W_DEF,
  parameter int unsigned HIGH_W = HIGH_W_DEF,
  localparam int unsigned W     = LOW_W + HIGH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] preset,
  input  logic         cnt_en,
  input  logic         dir_up,
  output logic [W-1:0] count,
  output logic         tc_low,
  output logic         tc_full
);
  logic [LOW_W-1:0]  lo_q;
  logic [HIGH_W-1:0] hi_q;
  logic              hi_step;  // event: carry moves the high stage

  assign hi_step = cnt_en & tc_low;

  cnt_stage #(.W(LOW_W)) u_lo (
    .clk(clk), .clr_n(rst_n), .ld(load), .ld_val(preset[LOW_W-1:0]),
    .step(cnt_en), .up(dir_up), .tc_gate(1'b1), .q(lo_q), .tc(tc_low));

  cnt_stage #(.W(HIGH_W)) u_hi (
    .clk(clk), .clr_n(rst_n), .ld(load), .ld_val(preset[W-1:LOW_W]),
    .step(hi_step), .up(dir_up), .tc_gate(tc_low), .q(hi_q), .tc(tc_full));

  assign count = {hi_q, lo_q};

  // R1: clear holds the count at zero
  always_ff @(posedge clk) begin
    if (!rst_n) p_clear_zero_r1: assert (count == '0);
  end

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(preset));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_en) |=> $stable(count));

  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && dir_up) |=> count == W'($past(count) + 1'b1));

  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && !dir_up) |=> count == W'($past(count) - 1'b1));

  p_full_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && count == {W{1'b1}}) |-> tc_full);

  p_full_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_up && count == '0) |-> tc_full);

  p_low_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && count[LOW_W-1:0] == {LOW_W{1'b1}}) |-> tc_low);

  p_high_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !hi_step) |=> count[W-1:LOW_W] == $past(count[W-1:LOW_W]));
endmodule

// File: tb/chained_updown_counter_bench.sv
module chained_updown_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        load = 1'b0;
  logic [11:0] preset = '0;
  logic        cnt_en = 1'b0;
  logic        dir_up = 1'b0;
  logic [11:0] count;
  logic        tc_low, tc_full;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  chained_updown_counter u_chained_updown_counter (
    .clk(clk), .rst_n(rst_n), .load(load), .preset(preset), .cnt_en(cnt_en),
    .dir_up(dir_up), .count(count), .tc_low(tc_low), .tc_full(tc_full));

  // vector: {load, preset[11:0], en, up, exp_count[11:0], exp_tc_full, exp_tc_low}
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 12'h0FE, 1'b0, 1'b1, 12'h0FE, 1'b0, 1'b0},  // R2 load
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h0FF, 1'b0, 1'b1},  // R4, R7
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h100, 1'b0, 1'b0},  // R8 carry up
    {1'b0, 12'h000, 1'b1, 1'b0, 12'h0FF, 1'b0, 1'b0},  // R5, R8 borrow
    {1'b0, 12'h000, 1'b1, 1'b0, 12'h0FE, 1'b0, 1'b0},  // R5
    {1'b1, 12'hF01, 1'b1, 1'b0, 12'hF01, 1'b0, 1'b0},  // R2 enable ignored
    {1'b0, 12'h000, 1'b1, 1'b0, 12'hF00, 1'b0, 1'b1},  // R7 down
    {1'b0, 12'h000, 1'b0, 1'b0, 12'hF00, 1'b0, 1'b1},  // R3, R7 enable low
    {1'b0, 12'h000, 1'b1, 1'b0, 12'hEFF, 1'b0, 1'b0},  // R8 borrow
    {1'b1, 12'hFFE, 1'b0, 1'b1, 12'hFFE, 1'b0, 1'b0},  // R2
    {1'b0, 12'h000, 1'b1, 1'b1, 12'hFFF, 1'b1, 1'b1},  // R6 up
    {1'b0, 12'h000, 1'b0, 1'b1, 12'hFFF, 1'b1, 1'b1},  // R3, R6
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h000, 1'b0, 1'b0},  // R4 wrap
    {1'b0, 12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 1'b1},  // R6 down
    {1'b0, 12'h000, 1'b1, 1'b0, 12'hFFF, 1'b0, 1'b0},  // R5 wrap
    {1'b1, 12'hA5C, 1'b1, 1'b1, 12'hA5C, 1'b0, 1'b0},  // R2 direction ignored
    {1'b0, 12'h000, 1'b0, 1'b1, 12'hA5C, 1'b0, 1'b0}   // R3
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge_step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] model;
    #1 rst_n = 1'b0;
    edge_step();
    check("R1 reset count", count, 12'h000);
    check("R6 reset down flag", {11'd0, tc_full}, 12'd1);
    dir_up = 1'b1;
    #1 check("R6 reset up flag", {11'd0, tc_full}, 12'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {load, preset, cnt_en, dir_up} = VEC[i][28:14];
      edge_step();
      check("R2-5 table count", count, VEC[i][13:2]);
      check("R6 table tc_full", {11'd0, tc_full}, {11'd0, VEC[i][1]});
      check("R7 table tc_low", {11'd0, tc_low}, {11'd0, VEC[i][0]});
    end

    // R1: clear acts between edges and wins over load
    @(negedge clk);
    load = 1'b0; cnt_en = 1'b0;
    rst_n = 1'b0;
    #0.5 check("R1 async clear", count, 12'h000);
    load = 1'b1; preset = 12'h3C3;
    edge_step();
    check("R1 clear over load", count, 12'h000);
    @(negedge clk) rst_n = 1'b1; load = 1'b0;

    // R8: enable high but low byte not terminal: high nibble unchanged
    @(negedge clk) load = 1'b1; preset = 12'h350;
    edge_step();
    @(negedge clk) load = 1'b0; cnt_en = 1'b1; dir_up = 1'b1;
    edge_step();
    check("R8 no carry", count, 12'h351);

    // R8: low byte terminal, enable low: no step of the high nibble
    @(negedge clk) load = 1'b1; preset = 12'h37F; cnt_en = 1'b0;
    edge_step();
    @(negedge clk) load = 1'b0; preset = 12'h3FF; load = 1'b1;
    edge_step();
    @(negedge clk) load = 1'b0;
    edge_step();
    edge_step();
    check("R8 gated by enable", count, 12'h3FF);
    check("R7 flag with enable low", {11'd0, tc_low}, 12'd1);

    // R4, R8: full up walk from zero against a bench model
    @(negedge clk) load = 1'b1; preset = 12'h000;
    edge_step();
    model = 12'h000;
    @(negedge clk) load = 1'b0; cnt_en = 1'b1; dir_up = 1'b1;
    for (int k = 0; k < 4096; k++) begin
      edge_step();
      model = model + 12'd1;
      if (count !== model) check("R4 walk", count, model);
    end
    check("R4 walk end wrapped", count, 12'h000);
    cnt_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule